// File: doc/BRIEF.md
# Per-Channel Window Compare and Interrupt Unit

This block takes 12-bit conversion results, each tagged with a channel number from 0 to 3, and turns them into software-visible state and one interrupt line. Each result overwrites a per-channel latest-value register and enters a 32-entry sample FIFO. If window comparison is enabled for its channel, the result is also checked against that channel's programmable upper and lower limits.

Three kinds of per-channel event feed sticky pending bits: data arrived, above upper limit, and below lower limit. The FIFO adds two more: a sample was stored, and a sample was lost because the FIFO was full. Software clears pending bits by writing 1 to them. Each pending bit has an enable bit. The interrupt output is high while any enabled pending bit is set. Software drains the FIFO by reading its data word, and can empty it at once with a self-clearing flush bit.

The register port is word addressed. Reads are combinational from the current state. A read of the FIFO data word pops the FIFO at the next clock edge.

Top module: `cmp_irq_unit`

## Requirements
- R1: After reset, every limit word (addresses 8 to 11) reads 0x0BFF_0400, which is upper limit 0xBFF and lower limit 0x400. The event pending word (5) and the FIFO status word (2) read 0, and `irq_o` is low.
- R2: One cycle after a result strobe, the latest-value word for the tagged channel (address 12+ch, bits 11:0) holds that result.
- R3: Every result sets data-event bit ch (bits 3:0 of word 5), whether or not comparison is enabled for that channel.
- R4: With compare enable bit 4+ch of word 0 set, a result strictly greater than the channel's upper limit sets bit 4+ch of word 5. A result equal to the limit sets nothing.
- R5: With the compare enable set, a result strictly less than the channel's lower limit sets bit 8+ch of word 5. A result equal to the limit sets nothing.
- R6: With the compare enable clear, a result sets no upper or lower event for that channel.
- R7: A limit word holds the upper limit in bits 27:16 and the lower limit in bits 11:0. Both are writable, and every other bit reads 0.
- R8: The FIFO returns results in arrival order. A read of word 3 returns the oldest entry in bits 11:0 and pops it. Bits 13:8 of word 2 give the number of entries.
- R9: The FIFO holds 32 entries. A result that arrives while the FIFO is full is dropped and sets the overrun flag, bit 17 of word 2.
- R10: Every result stored in the FIFO sets the data flag, bit 16 of word 2.
- R11: Writing 1 to bit 4 of word 1 empties the FIFO by the next cycle, and any result that arrives in the same cycle is discarded. Bit 4 always reads 0.
- R12: Writing 1 to a pending bit (word 5 bits 11:0, word 2 bits 17:16) clears it, and writing 0 leaves it unchanged. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R13: `irq_o` is the OR of word 5 ANDed with the enables in word 4, together with word 2 bits 17:16 ANDed with the enables in word 1 bits 17:16. Pending bits latch whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Conversion result strobe |
| res_chan_i | input | 2 | Channel tag of the result |
| res_data_i | input | 12 | Conversion result |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops FIFO at word 3) |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
On one channel, the window comparison is swept over every one of the 4096 possible result values against the reset limits. This separates strict from inclusive comparisons at both edges and checks every value in between. The other channels are driven with values at and next to each limit, which exposes bit-position mix-ups between channels. Reprogrammed limits with junk in the reserved bits confirm the field mask and the compare source. A 40-sample burst with a known arithmetic sequence distinguishes ordering, depth, drop-on-full and overrun flagging. Coincident stimulus (clear with event, flush with push) settles which action wins in the same cycle.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int unsigned NCH    = 4;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_FCTL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_FSTAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_FDATA = 4'd3;
  localparam logic [ADDR_W-1:0] A_EVEN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVPD  = 4'd5;
  localparam logic [1:0]        A_THR_HI  = 2'b10;  // words 8..11
  localparam logic [1:0]        A_LAST_HI = 2'b11;  // words 12..15

  localparam int unsigned B_OVR     = 17;
  localparam int unsigned B_DAT     = 16;
  localparam int unsigned B_FLUSH   = 4;
  localparam int unsigned B_CMPEN   = 4;
  localparam int unsigned B_CNT     = 8;
  localparam int unsigned B_THR_UP  = 16;
  localparam int unsigned EV_W      = 3 * NCH;

  localparam logic [31:0] THR_RST = 32'h0BFF_0400;
endpackage

// File: rtl/cmp_sample_fifo.sv
module cmp_sample_fifo #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          accept_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          empty, do_push, do_pop;

  assign empty    = (cnt_q == '0);
  assign full_o   = (cnt_q == CW'(DEPTH));
  assign do_push  = push_i & ~full_o & ~flush_i;
  assign do_pop   = pop_i & ~empty & ~flush_i;
  assign accept_o = do_push;
  assign count_o  = cnt_q;
  assign data_o   = empty ? '0 : mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cmp_chan_window.sv
module cmp_chan_window
  import cmp_irq_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          thr_we_i,
  input  logic [DW-1:0] thr_up_i,
  input  logic [DW-1:0] thr_lo_i,
  input  logic          hit_i,
  input  logic [DW-1:0] res_i,
  input  logic          cmp_en_i,
  output logic [31:0]   thr_o,
  output logic [DW-1:0] last_o,
  output logic          ev_data_o,
  output logic          ev_up_o,
  output logic          ev_lo_o
);
  logic [DW-1:0] up_q, lo_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= THR_RST[B_THR_UP +: DW];
      lo_q   <= THR_RST[0 +: DW];
      last_q <= '0;
    end else begin
      if (thr_we_i) begin
        up_q <= thr_up_i;
        lo_q <= thr_lo_i;
      end
      if (hit_i) last_q <= res_i;
    end
  end

  always_comb begin
    thr_o = '0;
    thr_o[B_THR_UP +: DW] = up_q;
    thr_o[0 +: DW]        = lo_q;
  end

  assign last_o    = last_q;
  assign ev_data_o = hit_i;
  assign ev_up_o   = hit_i & cmp_en_i & (res_i > up_q);
  assign ev_lo_o   = hit_i & cmp_en_i & (res_i < lo_q);
endmodule

// File: rtl/cmp_pend_bank.sv
module cmp_pend_bank #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cmp_irq_unit.sv
module cmp_irq_unit
  import cmp_irq_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [1:0]        res_chan_i,
  input  logic [DW-1:0]     res_data_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic [NCH-1:0]  cmp_en_q;
  logic [EV_W-1:0] ev_en_q;
  logic [1:0]      f_en_q;
  logic [EV_W-1:0] ev_pend, ev_clr;
  logic [1:0]      f_pend, f_clr, f_set;
  logic [NCH-1:0]  ev_d, ev_u, ev_l;
  logic [31:0]     thr_rd [NCH];
  logic [DW-1:0]   last_rd [NCH];
  logic [DW-1:0]   fifo_dout;
  logic [CW-1:0]   fifo_cnt;
  logic            fifo_full, fifo_acc, flush, pop;
  logic            unused_wd;

  assign unused_wd = ^reg_wdata_i;

  assign flush = reg_we_i & (reg_addr_i == A_FCTL) & reg_wdata_i[B_FLUSH];
  assign pop   = reg_re_i & (reg_addr_i == A_FDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_en_q <= '0;
      ev_en_q  <= '0;
      f_en_q   <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CFG:   cmp_en_q <= reg_wdata_i[B_CMPEN +: NCH];
        A_FCTL:  f_en_q   <= {reg_wdata_i[B_OVR], reg_wdata_i[B_DAT]};
        A_EVEN:  ev_en_q  <= reg_wdata_i[EV_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit, thr_we;
    assign hit    = res_valid_i & (res_chan_i == 2'(g));
    assign thr_we = reg_we_i & (reg_addr_i == {A_THR_HI, 2'(g)});

    cmp_chan_window #(.DW(DW)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .thr_we_i (thr_we),
      .thr_up_i (reg_wdata_i[B_THR_UP +: DW]),
      .thr_lo_i (reg_wdata_i[0 +: DW]),
      .hit_i    (hit),
      .res_i    (res_data_i),
      .cmp_en_i (cmp_en_q[g]),
      .thr_o    (thr_rd[g]),
      .last_o   (last_rd[g]),
      .ev_data_o(ev_d[g]),
      .ev_up_o  (ev_u[g]),
      .ev_lo_o  (ev_l[g])
    );
  end

  cmp_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (res_valid_i),
    .data_i  (res_data_i),
    .pop_i   (pop),
    .data_o  (fifo_dout),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .accept_o(fifo_acc)
  );

  assign ev_clr = (reg_we_i && reg_addr_i == A_EVPD) ? reg_wdata_i[EV_W-1:0] : '0;
  assign f_clr  = (reg_we_i && reg_addr_i == A_FSTAT) ?
                  {reg_wdata_i[B_OVR], reg_wdata_i[B_DAT]} : 2'b00;
  assign f_set  = {res_valid_i & fifo_full, fifo_acc};

  cmp_pend_bank #(.W(EV_W)) u_ev_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({ev_l, ev_u, ev_d}),
    .clr_i (ev_clr),
    .pend_o(ev_pend)
  );

  cmp_pend_bank #(.W(2)) u_f_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (f_set),
    .clr_i (f_clr),
    .pend_o(f_pend)
  );

  assign irq_o = (|(ev_pend & ev_en_q)) | (|(f_pend & f_en_q));

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[3:2] == A_THR_HI) begin
      reg_rdata_o = thr_rd[reg_addr_i[1:0]];
    end else if (reg_addr_i[3:2] == A_LAST_HI) begin
      reg_rdata_o[DW-1:0] = last_rd[reg_addr_i[1:0]];
    end else begin
      case (reg_addr_i)
        A_CFG:   reg_rdata_o[B_CMPEN +: NCH] = cmp_en_q;
        A_FCTL:  {reg_rdata_o[B_OVR], reg_rdata_o[B_DAT]} = f_en_q;
        A_FSTAT: begin
          {reg_rdata_o[B_OVR], reg_rdata_o[B_DAT]} = f_pend;
          reg_rdata_o[B_CNT +: CW] = fifo_cnt;
        end
        A_FDATA: reg_rdata_o[DW-1:0] = fifo_dout;
        A_EVEN:  reg_rdata_o[EV_W-1:0] = ev_en_q;
        A_EVPD:  reg_rdata_o[EV_W-1:0] = ev_pend;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmp_irq_checker.sv
module cmp_irq_checker
  import cmp_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_valid_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              irq_o,
  input logic [CW-1:0]     fifo_cnt,
  input logic [EV_W-1:0]   ev_pend,
  input logic [EV_W-1:0]   ev_en_q,
  input logic [1:0]        f_pend,
  input logic [1:0]        f_en_q
);
  logic flush_wr;
  assign flush_wr = reg_we_i && reg_addr_i == A_FCTL && reg_wdata_i[B_FLUSH];

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fifo_cnt) <= int'(DEPTH)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> fifo_cnt == '0); // R11

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_wr |=> (int'(fifo_cnt) <= int'($past(fifo_cnt)) + 1) &&
                  (int'(fifo_cnt) + 1 >= int'($past(fifo_cnt)))); // R8

  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && int'(fifo_cnt) == int'(DEPTH)) |=> f_pend[1]); // R9

  AST_EV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_EVPD) |=>
      ((ev_pend & $past(ev_pend)) == $past(ev_pend))); // R12

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_en_q == '0 && f_en_q == 2'b00) |-> !irq_o); // R13
endmodule

bind cmp_irq_unit cmp_irq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .res_valid_i(res_valid_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .fifo_cnt   (fifo_cnt),
  .ev_pend    (ev_pend),
  .ev_en_q    (ev_en_q),
  .f_pend     (f_pend),
  .f_en_q     (f_en_q)
);

// File: tb/tb_cmp_irq_unit.sv
`timescale 1ns/1ps
module tb_cmp_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [1:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(res_valid), .res_chan_i(res_chan),
    .res_data_i(res_data), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic rd_pop(output logic [31:0] d);
    reg_addr = 4'd3; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic push(input logic [1:0] c, input logic [11:0] v);
    res_valid = 1'b1; res_chan = c; res_data = v;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  function automatic logic [31:0] ev_exp(input int c, input int v, input int up, input int lo);
    logic [31:0] e = 32'(1) << c;
    if (v > up) e |= 32'(1) << (4 + c);
    if (v < lo) e |= 32'(1) << (8 + c);
    return e;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bnd[8] = '{0, 12'h3FF, 12'h400, 12'h401, 12'hBFE, 12'hBFF, 12'hC00, 12'hFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(4'(8 + c), d); chk("R1 limit reset", d, 32'h0BFF_0400);
    end
    rd(4'd5, d); chk("R1 event pending reset", d, 0);
    rd(4'd2, d); chk("R1 fifo status reset", d, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);

    // R3 R4 R5 full sweep on channel 0, boundaries on 1..3; R2 latest value
    wr(4'd0, 32'h0000_00F0);
    for (int v = 0; v < 4096; v++) begin
      push(2'd0, 12'(v));
      rd(4'd5, d); chk("R3/R4/R5 sweep ch0", d, ev_exp(0, v, 'hBFF, 'h400));
      if ((v % 256) == 7) begin
        rd(4'd12, d); chk("R2 latest ch0", d, 32'(v));
      end
      wr(4'd5, 32'hFFF);
    end
    for (int c = 1; c < 4; c++) begin
      foreach (bnd[i]) begin
        push(2'(c), 12'(bnd[i]));
        rd(4'd5, d); chk("R3/R4/R5 edges", d, ev_exp(c, bnd[i], 'hBFF, 'h400));
        rd(4'(12 + c), d); chk("R2 latest", d, 32'(bnd[i]));
        wr(4'd5, 32'hFFF);
      end
    end
    rd(4'd5, d); chk("R12 clear all", d, 0);

    // R6 comparison disabled
    wr(4'd0, 32'h0);
    push(2'd2, 12'hFFF); push(2'd2, 12'h000);
    rd(4'd5, d); chk("R6 no window events", d, 32'h004);
    wr(4'd5, 32'hFFF);

    // R7 reprogrammed limits, reserved bits dropped
    wr(4'd9, 32'hF200_F100);
    rd(4'd9, d); chk("R7 limit readback", d, 32'h0200_0100);
    wr(4'd0, 32'h0000_00F0);
    foreach (bnd[i]) begin end
    begin
      int tv[4] = '{'h201, 'h200, 'h0FF, 'h100};
      foreach (tv[i]) begin
        push(2'd1, 12'(tv[i]));
        rd(4'd5, d); chk("R7 new limits", d, ev_exp(1, tv[i], 'h200, 'h100));
        wr(4'd5, 32'hFFF);
      end
    end

    // R11 flush, R8 ordering, R9 depth and overrun, R10 data flag
    wr(4'd1, 32'h10);
    rd(4'd1, d); chk("R11 flush self-clears", d & 32'h10, 0);
    wr(4'd2, 32'h0003_0000);
    rd(4'd2, d); chk("R11 flush empties", d, 0);
    for (int k = 0; k < 40; k++) begin
      push(2'(k % 4), 12'(k * 37 + 5));
      if (k == 31) begin
        rd(4'd2, d); chk("R9 full, no overrun", d, 32'h0001_2000);
      end
    end
    rd(4'd2, d); chk("R9 overrun after full", d, 32'h0003_2000);
    for (int k = 0; k < 32; k++) begin
      rd_pop(d); chk("R8 fifo order", d, 32'(k * 37 + 5));
      if (k == 15) begin
        rd(4'd2, d); chk("R8 count after pops", d & 32'h3F00, 32'h1000);
      end
    end
    rd(4'd2, d); chk("R8 drained", d, 32'h0003_0000);
    wr(4'd2, 32'h0001_0000);
    rd(4'd2, d); chk("R12 clear data flag only", d, 32'h0002_0000);
    wr(4'd2, 32'h0002_0000);
    push(2'd0, 12'h555);
    rd(4'd2, d); chk("R10 data flag on store", d, 32'h0001_0100);
    // flush and push together: nothing stored
    res_valid = 1'b1; res_chan = 2'd0; res_data = 12'h777;
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h10;
    @(negedge clk);
    res_valid = 1'b0; reg_we = 1'b0;
    rd(4'd2, d); chk("R11 flush beats push", d & 32'h3F00, 0);

    // R12 set wins over clear, zero writes ignored
    wr(4'd5, 32'hFFF);
    push(2'd3, 12'h000);
    rd(4'd5, d); chk("R12 low event ch3", d, 32'h808);
    res_valid = 1'b1; res_chan = 2'd3; res_data = 12'h000;
    reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'hFFF;
    @(negedge clk);
    res_valid = 1'b0; reg_we = 1'b0;
    rd(4'd5, d); chk("R12 set wins", d, 32'h808);
    wr(4'd5, 32'h0);
    rd(4'd5, d); chk("R12 zero write no effect", d, 32'h808);
    wr(4'd5, 32'h008);
    rd(4'd5, d); chk("R12 selective clear", d, 32'h800);

    // R13 interrupt combining
    wr(4'd2, 32'h0003_0000);
    chk("R13 pending but disabled", {31'd0, irq}, 0);
    wr(4'd4, 32'h800);
    chk("R13 enabled low event", {31'd0, irq}, 1);
    wr(4'd4, 32'h001);
    chk("R13 other enable only", {31'd0, irq}, 0);
    push(2'd0, 12'h600);
    chk("R13 data event ch0 enabled", {31'd0, irq}, 1);
    wr(4'd4, 32'h0); wr(4'd5, 32'hFFF);
    chk("R13 all cleared", {31'd0, irq}, 0);
    wr(4'd1, 32'h0001_0000);
    chk("R13 fifo data flag enabled", {31'd0, irq}, 1);
    wr(4'd2, 32'h0001_0000);
    chk("R13 fifo flag cleared", {31'd0, irq}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule